// File: doc/BRIEF.md
# GPIO Input Event Detector

This block watches a small bank of general-purpose pins and latches a sticky status flag for each pin whose input reaches its active level and holds it there. A per-pin polarity bit chooses whether the active level is high or low. Only a pin that is selected as a GPIO (its use-select bit is set) and driven as an input (its output enable is clear) can raise its flag. Each input goes through a two-flop synchronizer and then a small per-pin qualifier state machine. The flag is set only after the synchronized level has been active for two consecutive clocks, so a one-clock glitch is rejected. A combined event output is high while any enabled pin has its flag set.

Software reaches three 32-bit registers over a plain read/write port. The status register sits at 0x28, the polarity register at 0x2C and the use-select register at 0x30. Twelve pins are implemented. Dense pin k maps to register bit k for k = 0..8, and to bit k+2 for k = 9..11, so the implemented bits are 13:11, 8 and 7:0. The pins are split between two reset domains. The core domain holds bits 7:0 and the use-select register, and it clears on the core reset. The resume domain holds bits 13:11 and 8, and it clears on the resume reset or on a one-clock soft-reset strobe.

Each pin's qualifier has three states. QUAL_IDLE moves to QUAL_COUNT (transition "arm") when the pin is enabled and active. QUAL_COUNT moves to QUAL_LATCHED (transition "fire") when the pin is still active and enabled on the qualifying clock, and this sets the status flag. QUAL_COUNT drops back to QUAL_IDLE (transition "abort") if the level goes inactive or the pin is disabled. QUAL_LATCHED returns to QUAL_IDLE (transition "release") once the level goes inactive or the pin is disabled. A domain reset or the soft strobe, for resume pins, forces QUAL_IDLE.

Top module: `gpio_evt_top`

## Requirements
- R1: With polarity bit 0 the pin's status bit is set by a high input; with polarity bit 1 it is set by a low input.
- R2: An input must be active for at least two consecutive clocks to set status; a one-clock pulse sets nothing.
- R3: A pin with its output enable high, or with its use-select bit 0 (native function), never sets its status bit, whatever its polarity.
- R4: Status bits (register 0x28, same bit positions as polarity) are sticky; writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R5: event_o is high exactly when some pin has status set, use-select 1 and output enable 0; a status bit of a disabled pin stays readable but does not drive event_o.
- R6: The polarity register at 0x2C resets to 0; only bits 13:11, 8 and 7:0 are writable, and all other bits read 0.
- R7: The use-select register at 0x30 holds bit k for dense pin k in bits 11:0 (1 = GPIO, 0 = native), resets to 0x00000FFF, and its bits 31:12 read 0 and ignore writes.
- R8: After reset the status register reads 0 and event_o is low.
- R9: The core reset clears polarity and status bits 7:0 and returns use-select to 0xFFF, leaving bits 13:11 and 8 untouched.
- R10: The resume reset clears polarity and status bits 13:11 and 8, leaving bits 7:0 and use-select untouched.
- R11: A one-clock soft_rst strobe clears the resume-domain polarity and status bits by the next clock, and leaves the core-domain bits and use-select unchanged.
- R12: Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_core_n | input | 1 | Asynchronous active-low core-domain reset |
| rst_res_n | input | 1 | Asynchronous active-low resume-domain reset |
| soft_rst | input | 1 | One-clock strobe clearing the resume domain |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write enable for reg_wdata at reg_addr |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | 12 | Raw pin levels, dense pin order |
| pin_oe | input | 12 | Per-pin output enable; 1 makes the pin an output |
| event_o | output | 1 | OR of status over enabled input pins |

## Verification
The assertions assume that the pin inputs are asynchronous but change at most once per clock. They also assume that the two reset inputs are driven as clean levels held for at least one clock, and that soft_rst is a strobe sampled on the rising edge. The stimulus follows these assumptions. It changes pins, enables, addresses and strobes only on the falling clock edge, and it holds each reset low for two full cycles. It also waits six clocks after every pin change so that the synchronizer and qualifier have settled before status is read.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        QUAL_IDLE    = 2'd0,
        QUAL_COUNT   = 2'd1,
        QUAL_LATCHED = 2'd2
    } qual_state_e;

    localparam logic [7:0] OFS_STATUS   = 8'h28;
    localparam logic [7:0] OFS_POLARITY = 8'h2C;
    localparam logic [7:0] OFS_USESEL   = 8'h30;

    function automatic int count_ones(input logic [REG_W-1:0] mask);
        int n;
        n = 0;
        for (int b = 0; b < REG_W; b++) begin
            if (mask[b]) n++;
        end
        return n;
    endfunction

    // register bit position of the k-th implemented pin
    function automatic int pin_pos(input logic [REG_W-1:0] mask, input int k);
        int seen;
        seen = 0;
        for (int b = 0; b < REG_W; b++) begin
            if (mask[b]) begin
                if (seen == k) return b;
                seen++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else if (clr) begin
            meta_q   <= 1'b0;
            stable_q <= 1'b0;
        end else begin
            meta_q   <= d;
            stable_q <= meta_q;
        end
    end

    assign q = stable_q;
endmodule

// File: rtl/gpio_evt_qual.sv
module gpio_evt_qual
    import gpio_evt_pkg::*;
#(
    parameter int QUAL_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic active,
    output logic set_o
);
    localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYCLES - 1);

    qual_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic live;

    assign live = en && active;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QUAL_IDLE;
            cnt_q   <= '0;
        end else if (clr) begin
            state_q <= QUAL_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            QUAL_IDLE: begin
                if (live) begin            // arm
                    state_d = QUAL_COUNT;
                    cnt_d   = CNT_W'(1);
                end
            end
            QUAL_COUNT: begin
                if (!live) begin           // abort
                    state_d = QUAL_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin  // fire
                    state_d = QUAL_LATCHED;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + CNT_W'(1);
                end
            end
            QUAL_LATCHED: begin
                if (!live) begin           // release
                    state_d = QUAL_IDLE;
                end
            end
            default: begin
                state_d = QUAL_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        set_o = 1'b0;
        unique case (state_q)
            QUAL_COUNT:   set_o = live && (cnt_q == CNT_LAST);
            QUAL_IDLE,
            QUAL_LATCHED: set_o = 1'b0;
            default:      set_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL_MASK   = 32'h0000_39FF,
    parameter logic [REG_W-1:0] RESUME_MASK = 32'h0000_3900,
    parameter int               ADDR_W      = 8,
    parameter int               NUM_PINS    = 12
) (
    input  logic                clk,
    input  logic                rst_core_n,
    input  logic                rst_res_n,
    input  logic                soft_clr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [NUM_PINS-1:0] sts_set,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] use_o,
    output logic [NUM_PINS-1:0] sts_o,
    output logic [REG_W-1:0]    rd_data
);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(OFS_POLARITY);
    localparam logic [ADDR_W-1:0] A_USE = ADDR_W'(OFS_USESEL);

    logic wr_sts, wr_pol, wr_use;
    logic [NUM_PINS-1:0] use_q;
    logic [REG_W-1:0] unused_wr_bits;

    assign wr_sts = wr_en && (addr == A_STS);
    assign wr_pol = wr_en && (addr == A_POL);
    assign wr_use = wr_en && (addr == A_USE);
    assign unused_wr_bits = wr_data & ~IMPL_MASK;

    function automatic logic [REG_W-1:0] spread(input logic [NUM_PINS-1:0] d);
        logic [REG_W-1:0] w;
        w = '0;
        for (int k = 0; k < NUM_PINS; k++) begin
            w[pin_pos(IMPL_MASK, k)] = d[k];
        end
        return w;
    endfunction

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        localparam int POS = pin_pos(IMPL_MASK, k);
        logic dom_rst_n;
        logic dom_clr;
        logic pol_bit;
        logic sts_bit;

        if (RESUME_MASK[POS]) begin : g_res
            assign dom_rst_n = rst_res_n;
            assign dom_clr   = soft_clr;
        end else begin : g_core
            assign dom_rst_n = rst_core_n;
            assign dom_clr   = 1'b0;
        end

        always_ff @(posedge clk or negedge dom_rst_n) begin
            if (!dom_rst_n) begin
                pol_bit <= 1'b0;
                sts_bit <= 1'b0;
            end else if (dom_clr) begin
                pol_bit <= 1'b0;
                sts_bit <= 1'b0;
            end else begin
                if (wr_pol) pol_bit <= wr_data[POS];
                if (sts_set[k]) sts_bit <= 1'b1;
                else if (wr_sts && wr_data[POS]) sts_bit <= 1'b0;
            end
        end

        assign pol_o[k] = pol_bit;
        assign sts_o[k] = sts_bit;
    end

    // use-select lives in the core domain only
    always_ff @(posedge clk or negedge rst_core_n) begin
        if (!rst_core_n) begin
            use_q <= '1;
        end else if (wr_use) begin
            use_q <= wr_data[NUM_PINS-1:0];
        end
    end

    assign use_o = use_q;

    always_comb begin
        rd_data = '0;
        if (addr == A_STS)      rd_data = spread(sts_o);
        else if (addr == A_POL) rd_data = spread(pol_o);
        else if (addr == A_USE) rd_data[NUM_PINS-1:0] = use_q;
    end
endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
    import gpio_evt_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL_MASK   = 32'h0000_39FF,
    parameter logic [REG_W-1:0] RESUME_MASK = 32'h0000_3900,
    parameter int               ADDR_W      = 8,
    parameter int               QUAL_CYCLES = 2,
    localparam int              NUM_PINS    = count_ones(IMPL_MASK)
) (
    input  logic                clk,
    input  logic                rst_core_n,
    input  logic                rst_res_n,
    input  logic                soft_rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_oe,
    output logic                event_o
);
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] use_q;
    logic [NUM_PINS-1:0] sts_q;
    logic [NUM_PINS-1:0] sts_set;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] pin_en;
    logic [NUM_PINS-1:0] act_en;

    gpio_evt_regs #(
        .IMPL_MASK   (IMPL_MASK),
        .RESUME_MASK (RESUME_MASK),
        .ADDR_W      (ADDR_W),
        .NUM_PINS    (NUM_PINS)
    ) u_regs (
        .clk        (clk),
        .rst_core_n (rst_core_n),
        .rst_res_n  (rst_res_n),
        .soft_clr   (soft_rst),
        .addr       (reg_addr),
        .wr_en      (reg_wr),
        .wr_data    (reg_wdata),
        .sts_set    (sts_set),
        .pol_o      (pol_q),
        .use_o      (use_q),
        .sts_o      (sts_q),
        .rd_data    (reg_rdata)
    );

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        localparam int POS = pin_pos(IMPL_MASK, k);
        logic dom_rst_n;
        logic dom_clr;

        if (RESUME_MASK[POS]) begin : g_res
            assign dom_rst_n = rst_res_n;
            assign dom_clr   = soft_rst;
        end else begin : g_core
            assign dom_rst_n = rst_core_n;
            assign dom_clr   = 1'b0;
        end

        gpio_evt_sync u_sync (
            .clk   (clk),
            .rst_n (dom_rst_n),
            .clr   (dom_clr),
            .d     (pin_in[k]),
            .q     (pin_sync[k])
        );

        assign pin_en[k] = use_q[k] && !pin_oe[k];
        assign act_en[k] = pin_en[k] && (pin_sync[k] ^ pol_q[k]);

        gpio_evt_qual #(
            .QUAL_CYCLES (QUAL_CYCLES)
        ) u_qual (
            .clk    (clk),
            .rst_n  (dom_rst_n),
            .clr    (dom_clr),
            .en     (pin_en[k]),
            .active (pin_sync[k] ^ pol_q[k]),
            .set_o  (sts_set[k])
        );
    end

    assign event_o = |(sts_q & pin_en);
endmodule

// File: rtl/gpio_evt_chk.sv
module gpio_evt_chk
    import gpio_evt_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL_MASK   = 32'h0000_39FF,
    parameter logic [REG_W-1:0] RESUME_MASK = 32'h0000_3900,
    parameter int               ADDR_W      = 8,
    parameter int               NUM_PINS    = 12
) (
    input logic                clk,
    input logic                rst_core_n,
    input logic                rst_res_n,
    input logic                soft_rst,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [REG_W-1:0]    reg_rdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] sts_q,
    input logic [NUM_PINS-1:0] pol_q,
    input logic [NUM_PINS-1:0] act_en,
    input logic                event_o
);
    logic any_rst;
    logic [1:0] warm_q;
    logic [NUM_PINS-1:0] res_dense;

    assign any_rst = !rst_core_n || !rst_res_n;

    always_comb begin
        res_dense = '0;
        for (int k = 0; k < NUM_PINS; k++) begin
            res_dense[k] = RESUME_MASK[pin_pos(IMPL_MASK, k)];
        end
    end

    always_ff @(posedge clk or posedge any_rst) begin
        if (any_rst) warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        AST_QUAL_TWO_CLOCKS: assert property (@(posedge clk) disable iff (any_rst)
            (warm_q >= 2'd2) && $rose(sts_q[k]) |-> $past(act_en[k]) && $past(act_en[k], 2)); // R2
        AST_OUTPUT_SILENT: assert property (@(posedge clk) disable iff (any_rst)
            pin_oe[k] && !sts_q[k] |=> !sts_q[k]); // R3
    end

    AST_EVENT_NEEDS_STATUS: assert property (@(posedge clk) disable iff (any_rst)
        event_o |-> (sts_q != '0)); // R5
    AST_POL_RSV_ZERO: assert property (@(posedge clk) disable iff (any_rst)
        (reg_addr == ADDR_W'(OFS_POLARITY)) |-> ((reg_rdata & ~IMPL_MASK) == '0)); // R6
    AST_USE_HIGH_ZERO: assert property (@(posedge clk) disable iff (any_rst)
        (reg_addr == ADDR_W'(OFS_USESEL)) |-> (reg_rdata[REG_W-1:NUM_PINS] == '0)); // R7
    AST_SOFT_CLEARS_RESUME: assert property (@(posedge clk) disable iff (any_rst)
        soft_rst |=> ((pol_q & res_dense) == '0) && ((sts_q & res_dense) == '0)); // R11
endmodule

bind gpio_evt_top gpio_evt_chk #(
    .IMPL_MASK   (IMPL_MASK),
    .RESUME_MASK (RESUME_MASK),
    .ADDR_W      (ADDR_W),
    .NUM_PINS    (NUM_PINS)
) u_chk (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .rst_res_n  (rst_res_n),
    .soft_rst   (soft_rst),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .pin_oe     (pin_oe),
    .sts_q      (sts_q),
    .pol_q      (pol_q),
    .act_en     (act_en),
    .event_o    (event_o)
);

// File: tb/sim_gpio_evt_top.sv
`timescale 1ns/1ps
module sim_gpio_evt_top;
    localparam int NP = 12;
    localparam logic [7:0] A_STS = 8'h28;
    localparam logic [7:0] A_POL = 8'h2C;
    localparam logic [7:0] A_USE = 8'h30;
    localparam logic [31:0] ALL_BITS = 32'h0000_39FF;
    localparam logic [31:0] RES_BITS = 32'h0000_3900;
    localparam logic [31:0] CORE_BITS = 32'h0000_00FF;

    logic clk = 1'b0;
    logic rst_core_n = 1'b0;
    logic rst_res_n = 1'b0;
    logic soft_rst = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_oe = '0;
    logic event_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_evt_top u0 (
        .clk        (clk),
        .rst_core_n (rst_core_n),
        .rst_res_n  (rst_res_n),
        .soft_rst   (soft_rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pin_in     (pin_in),
        .pin_oe     (pin_oe),
        .event_o    (event_o)
    );

    function automatic int bitpos(input int k);
        return (k < 9) ? k : k + 2;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input int k, input logic lvl, input int len);
        @(negedge clk);
        pin_in[k] = lvl;
        idle(len);
        pin_in[k] = ~lvl;
        idle(6);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_core_n = 1'b1; rst_res_n = 1'b1;
        idle(1);
        rd(A_POL, v); chk("R6 polarity reset", v, 32'h0);
        rd(A_USE, v); chk("R7 use-select reset", v, 32'h0000_0FFF);
        rd(A_STS, v); chk("R8 status reset", v, 32'h0);
        chk("R8 event reset", {31'b0, event_o}, 32'h0);

        // polarity sweep over every pin
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < NP; k++) begin
                logic act_lvl;
                act_lvl = (p == 0);
                pin_in = {NP{~act_lvl}};
                wr(A_POL, (p == 1) ? ALL_BITS : 32'h0);
                idle(6);
                wr(A_STS, 32'hFFFF_FFFF);
                rd(A_STS, v); chk("R4 clear all", v, 32'h0);
                pulse(k, act_lvl, 1);
                rd(A_STS, v); chk("R2 glitch rejected", v, 32'h0);
                pulse(k, act_lvl, 2);
                rd(A_STS, v); chk("R1 two-clock pulse", v, 32'h1 << bitpos(k));
                chk("R5 event raised", {31'b0, event_o}, 32'h1);
                wr(A_STS, ~(32'h1 << bitpos(k)));
                rd(A_STS, v); chk("R4 write zero keeps", v, 32'h1 << bitpos(k));
                wr(A_STS, 32'h1 << bitpos(k));
                rd(A_STS, v); chk("R4 write one clears", v, 32'h0);
            end
        end

        // output-enabled and native pins stay silent
        pin_in = '0;
        wr(A_POL, 32'h0);
        for (int k = 0; k < NP; k++) begin
            pin_oe[k] = 1'b1;
            pulse(k, 1'b1, 4);
            rd(A_STS, v); chk("R3 output pin silent", v, 32'h0);
            pin_oe[k] = 1'b0;
            wr(A_USE, 32'h0000_0FFF & ~(32'h1 << k));
            pulse(k, 1'b1, 4);
            rd(A_STS, v); chk("R3 native pin silent", v, 32'h0);
            wr(A_USE, 32'h0000_0FFF);
        end

        // event masking by output enable
        pulse(3, 1'b1, 3);
        pin_oe[3] = 1'b1;
        idle(1);
        chk("R5 masked event", {31'b0, event_o}, 32'h0);
        rd(A_STS, v); chk("R5 status kept", v, 32'h8);
        pin_oe[3] = 1'b0;
        idle(1);
        chk("R5 unmasked event", {31'b0, event_o}, 32'h1);
        wr(A_STS, 32'hFFFF_FFFF);

        // register field masking
        wr(A_POL, 32'hFFFF_FFFF);
        rd(A_POL, v); chk("R6 reserved ignored", v, ALL_BITS);
        wr(A_USE, 32'hFFFF_FFFF);
        rd(A_USE, v); chk("R7 upper ignored", v, 32'h0000_0FFF);
        wr(A_USE, 32'h0);
        rd(A_USE, v); chk("R7 cleared", v, 32'h0);
        rd(8'h34, v); chk("R12 unmapped", v, 32'h0);
        rd(8'h00, v); chk("R12 unmapped zero", v, 32'h0);

        // reset domains
        wr(A_USE, 32'h0000_0FFF);
        wr(A_POL, 32'h0);
        pin_in = '1;
        idle(6);
        wr(A_POL, ALL_BITS);
        wr(A_USE, 32'h0000_05A5);
        idle(6);
        rd(A_STS, v); chk("R1 all set", v, ALL_BITS);
        @(negedge clk); rst_core_n = 1'b0;
        idle(2); rst_core_n = 1'b1;
        rd(A_POL, v); chk("R9 core reset polarity", v, RES_BITS);
        rd(A_STS, v); chk("R9 core reset status", v, RES_BITS);
        rd(A_USE, v); chk("R9 core reset use", v, 32'h0000_0FFF);
        idle(6);
        wr(A_POL, ALL_BITS);
        wr(A_USE, 32'h0000_05A5);
        idle(6);
        rd(A_STS, v); chk("R9 core re-detect", v, ALL_BITS);
        @(negedge clk); rst_res_n = 1'b0;
        idle(2); rst_res_n = 1'b1;
        rd(A_POL, v); chk("R10 resume reset polarity", v, CORE_BITS);
        rd(A_STS, v); chk("R10 resume reset status", v, CORE_BITS);
        rd(A_USE, v); chk("R10 use untouched", v, 32'h0000_05A5);
        idle(6);
        wr(A_POL, ALL_BITS);
        idle(2);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        rd(A_POL, v); chk("R11 soft polarity", v, CORE_BITS);
        rd(A_STS, v); chk("R11 soft status", v, CORE_BITS);
        rd(A_USE, v); chk("R11 soft use", v, 32'h0000_05A5);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule